// File: doc/BRIEF.md
# Scratchpad Request Issue and Response Retirement Pipeline

This block sits between a vector execution pipeline and a shared on-chip scratchpad. It keeps two in-order queues. One holds requests that the vector pipeline has issued and that still have to go out to the scratchpad. The other holds responses that have come back and still have to be retired. In any cycle it can send at most one request and retire at most one response.

Sending is throttled by how full the response queue is. The head request leaves the queue in the same cycle it is offered, even if the scratchpad refuses it; a refusal is only flagged, and some other path retries it. The head response retires only when four things hold together: its latency has run out, the register file accepts the write (this is asked only of loads and returning atomics), the shared writeback bus is idle, and either co-issue is enabled or the owning pipe's wait timer is idle.

On retirement the block does three things. For loads and returning atomics it writes the response data into a per-lane register file, one destination register per cycle, widening 8-, 16- or 32-bit elements into 32- or 64-bit registers. It decrements the per-wavefront outstanding counters that match the operation class. It loads the bus timer, and when co-issue is disabled the pipe wait timer as well, with the response's hold time. The same counters count up by class when a request is accepted into the issue queue.

The write stage is a two-state machine. The states are WB_IDLE and WB_WRITE, with three transitions:
- WB_IDLE to WB_WRITE, when a load or returning atomic retires with a register count that is not zero.
- WB_WRITE to WB_WRITE, to move on to the next destination register.
- WB_WRITE to WB_IDLE, after the last destination register has been written.

Top module: `lmem_return_pipe`

## Requirements
- R1: `lds_req_valid` is high only while the response queue holds fewer than QDEPTH entries and the issue queue is not empty. The head request is then offered through `lds_req_op`, `lds_req_slot` and `lds_req_tag`.
- R2: An offered request is removed from the issue queue in that same cycle whether or not `lds_accept` is high. `lds_refused` is high exactly when a request is offered and `lds_accept` is low.
- R3: A response pushed with latency L retires no earlier than max(L,1) cycles after the clock edge that captured it.
- R4: Operation codes are 0 load, 1 store, 2 returning atomic, 3 non-returning atomic and 4 other store-like. A load or returning atomic at the head waits while `vrf_ready` is low. Every other class ignores `vrf_ready`.
- R5: A retirement loads the bus timer, and when `coissue_en` is low the wait timer of the response's pipe, with the response's hold time T. No further retirement happens within the next T cycles.
- R6: Only loads and returning atomics write registers. For register k (0 to nreg-1, one per cycle, starting the cycle after retirement), `rf_addr` is dst+k and lane i takes element k*LANES+i of the response data. Each element occupies 64 bits, element j at bits [64j+63:64j]. `rf_we` equals the execution mask. In every other cycle `rf_we` is zero.
- R7: The element size codes are 0 = 8, 1 = 16, 2 = 32 and 3 = 64 bits. Signed elements are sign-extended and unsigned elements are zero-extended. When `rf_wide` is low, bits 63:32 of each lane are zero.
- R8: Every retirement decrements its slot's total counter. The counter saturates at zero.
- R9: The read counter counts classes 0, 2 and 3. The write counter counts classes 1, 2, 3 and 4. Each counts up when a request of its class is accepted into the issue queue and down when a response of its class retires, saturating at zero.
- R10: After reset all counters are zero and no request, refusal or register write is signalled.
- R11: Responses retire strictly in arrival order. A ready response waits behind an unready head, and behind the write stage until that stage returns to WB_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coissue_en | input | 1 | When high, the pipe wait timers are neither checked nor loaded |
| iss_push | input | 1 | Enqueue an issued request |
| iss_op | input | 3 | Operation class of the issued request |
| iss_slot | input | SLOT_W | Wavefront slot of the issued request |
| iss_tag | input | TAG_W | Request tag |
| iss_full | output | 1 | Issue queue full (a push is dropped) |
| lds_req_valid | output | 1 | Request offered to the scratchpad |
| lds_req_op | output | 3 | Offered operation class |
| lds_req_slot | output | SLOT_W | Offered slot |
| lds_req_tag | output | TAG_W | Offered tag |
| lds_accept | input | 1 | Scratchpad takes the offered request |
| lds_refused | output | 1 | Offered request was refused |
| rsp_push | input | 1 | Enqueue a returned response |
| rsp_op | input | 3 | Response operation class |
| rsp_esz | input | 2 | Element size code |
| rsp_sgn | input | 1 | Element is signed |
| rsp_wide | input | 1 | Destination registers are 64-bit |
| rsp_dst | input | REG_W | First destination register |
| rsp_nreg | input | NREG_W | Number of destination registers (clamped to NREG_MAX) |
| rsp_mask | input | LANES | Execution mask |
| rsp_data | input | NREG_MAX*LANES*64 | Response elements |
| rsp_slot | input | SLOT_W | Wavefront slot |
| rsp_pipe | input | PIPE_W | Pipe identifier |
| rsp_time | input | TIME_W | Hold time for the bus and wait timers |
| rsp_lat | input | LAT_W | Latency before the response may retire |
| rsp_full | output | 1 | Response queue full |
| vrf_ready | input | 1 | Register file accepts a write |
| rf_we | output | LANES | Per-lane write enable |
| rf_addr | output | REG_W | Register being written |
| rf_wide | output | 1 | Write is 64-bit |
| rf_wdata | output | LANES*64 | Widened lane data |
| cnt_total | output | SLOTS*CNT_W | Total outstanding counters, slot s at bits [s*CNT_W +: CNT_W] |
| cnt_rd | output | SLOTS*CNT_W | Read outstanding counters |
| cnt_wr | output | SLOTS*CNT_W | Write outstanding counters |

## Verification
An issue push raises the counters and shows the request on the scratchpad port right after the capturing edge. Because the offered request leaves the queue at the next edge, the port shows the following request, or nothing, one cycle later. A response with latency L retires on edge max(L,1) after its push, and the counters change right after that edge. The write for register k appears k+1 cycles after the push edge plus the latency delay. A hold time T keeps the next retirement back by T+1 cycles. Each directed task counts these edges one by one from its push and samples every output on the falling edge of the cycle in which it is due, together with the cycle just before, so that a result arriving one cycle early or late is caught.

// File: rtl/lmr_pkg.sv
package lmr_pkg;

    typedef enum logic [2:0] {
        OP_LOAD       = 3'd0,
        OP_STORE      = 3'd1,
        OP_ATOM_RET   = 3'd2,
        OP_ATOM_NORET = 3'd3,
        OP_ST_OTHER   = 3'd4
    } op_e;

    typedef enum logic {
        WB_IDLE  = 1'b0,
        WB_WRITE = 1'b1
    } wb_state_e;

    function automatic logic writes_back(input logic [2:0] op);
        return (op == OP_LOAD) || (op == OP_ATOM_RET);
    endfunction

    function automatic logic counts_read(input logic [2:0] op);
        return (op == OP_LOAD) || (op == OP_ATOM_RET) || (op == OP_ATOM_NORET);
    endfunction

    function automatic logic counts_write(input logic [2:0] op);
        return (op == OP_STORE) || (op == OP_ATOM_RET) ||
               (op == OP_ATOM_NORET) || (op == OP_ST_OTHER);
    endfunction

    // widen an element of size code esz into a 32- or 64-bit lane value
    function automatic logic [63:0] widen(input logic [63:0] raw, input logic [1:0] esz,
                                          input logic sgn, input logic wide);
        logic [63:0] v;
        unique case (esz)
            2'd0:    v = sgn ? {{56{raw[7]}},  raw[7:0]}  : {56'd0, raw[7:0]};
            2'd1:    v = sgn ? {{48{raw[15]}}, raw[15:0]} : {48'd0, raw[15:0]};
            2'd2:    v = sgn ? {{32{raw[31]}}, raw[31:0]} : {32'd0, raw[31:0]};
            default: v = raw;
        endcase
        if (!wide) v[63:32] = '0;
        return v;
    endfunction

endpackage

// File: rtl/lmr_fifo.sv
module lmr_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic [CW-1:0]    count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    rd_ptr, wr_ptr;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= bump(wr_ptr);
            end
            if (do_pop) rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/lmr_timer.sv
module lmr_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         idle
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign idle = (cnt == '0);
endmodule

// File: rtl/lmr_ctr.sv
module lmr_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] val
);
    always_ff @(posedge clk) begin
        if (!rst_n)                                val <= '0;
        else if (inc && !dec && (val != '1))       val <= val + 1'b1;
        else if (dec && !inc && (val != '0))       val <= val - 1'b1;
    end
endmodule

// File: rtl/lmem_return_pipe.sv
module lmem_return_pipe
    import lmr_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int QDEPTH   = 4,
    parameter int SLOTS    = 4,
    parameter int PIPES    = 2,
    parameter int REGS     = 16,
    parameter int NREG_MAX = 2,
    parameter int TIME_W   = 4,
    parameter int LAT_W    = 6,
    parameter int CNT_W    = 4,
    parameter int TAG_W    = 4,
    localparam int SLOT_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int PIPE_W  = (PIPES > 1) ? $clog2(PIPES) : 1,
    localparam int REG_W   = (REGS > 1) ? $clog2(REGS) : 1,
    localparam int NREG_W  = $clog2(NREG_MAX + 1),
    localparam int DATA_W  = NREG_MAX * LANES * 64,
    localparam int CYC_W   = LAT_W + 1,
    localparam int QC_W    = $clog2(QDEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    coissue_en,
    input  logic                    iss_push,
    input  logic [2:0]              iss_op,
    input  logic [SLOT_W-1:0]       iss_slot,
    input  logic [TAG_W-1:0]        iss_tag,
    output logic                    iss_full,
    output logic                    lds_req_valid,
    output logic [2:0]              lds_req_op,
    output logic [SLOT_W-1:0]       lds_req_slot,
    output logic [TAG_W-1:0]        lds_req_tag,
    input  logic                    lds_accept,
    output logic                    lds_refused,
    input  logic                    rsp_push,
    input  logic [2:0]              rsp_op,
    input  logic [1:0]              rsp_esz,
    input  logic                    rsp_sgn,
    input  logic                    rsp_wide,
    input  logic [REG_W-1:0]        rsp_dst,
    input  logic [NREG_W-1:0]       rsp_nreg,
    input  logic [LANES-1:0]        rsp_mask,
    input  logic [DATA_W-1:0]       rsp_data,
    input  logic [SLOT_W-1:0]       rsp_slot,
    input  logic [PIPE_W-1:0]       rsp_pipe,
    input  logic [TIME_W-1:0]       rsp_time,
    input  logic [LAT_W-1:0]        rsp_lat,
    output logic                    rsp_full,
    input  logic                    vrf_ready,
    output logic [LANES-1:0]        rf_we,
    output logic [REG_W-1:0]        rf_addr,
    output logic                    rf_wide,
    output logic [LANES*64-1:0]     rf_wdata,
    output logic [SLOTS*CNT_W-1:0]  cnt_total,
    output logic [SLOTS*CNT_W-1:0]  cnt_rd,
    output logic [SLOTS*CNT_W-1:0]  cnt_wr
);
    typedef struct packed {
        logic [2:0]        op;
        logic [SLOT_W-1:0] slot;
        logic [TAG_W-1:0]  tag;
    } iss_t;

    typedef struct packed {
        logic [2:0]        op;
        logic [1:0]        esz;
        logic              sgn;
        logic              wide;
        logic [REG_W-1:0]  dst;
        logic [NREG_W-1:0] nreg;
        logic [LANES-1:0]  mask;
        logic [DATA_W-1:0] data;
        logic [SLOT_W-1:0] slot;
        logic [PIPE_W-1:0] pipe;
        logic [TIME_W-1:0] tval;
        logic [CYC_W-1:0]  due;
    } rsp_t;

    // ---------------- issue side ----------------
    iss_t            iq_in, iq_head;
    logic            iq_empty;
    logic [QC_W-1:0] iq_count, rq_count;
    logic            iss_take;
    rsp_t            rq_in, rq_head;
    logic            rq_empty;

    assign iq_in    = '{op: iss_op, slot: iss_slot, tag: iss_tag};
    assign iss_take = iss_push && !iss_full;

    lmr_fifo #(.WIDTH($bits(iss_t)), .DEPTH(QDEPTH)) u_issue_q (
        .clk(clk), .rst_n(rst_n), .push(iss_push), .din(iq_in), .pop(lds_req_valid),
        .dout(iq_head), .empty(iq_empty), .full(iss_full), .count(iq_count));

    assign lds_req_valid = !iq_empty && (rq_count < QC_W'(QDEPTH));
    assign lds_req_op    = iq_head.op;
    assign lds_req_slot  = iq_head.slot;
    assign lds_req_tag   = iq_head.tag;
    assign lds_refused   = lds_req_valid && !lds_accept;

    // ---------------- response side ----------------
    logic [CYC_W-1:0] cyc;

    always_ff @(posedge clk) begin
        if (!rst_n) cyc <= '0;
        else        cyc <= cyc + 1'b1;
    end

    assign rq_in = '{op: rsp_op, esz: rsp_esz, sgn: rsp_sgn, wide: rsp_wide, dst: rsp_dst,
                     nreg: rsp_nreg, mask: rsp_mask, data: rsp_data, slot: rsp_slot,
                     pipe: rsp_pipe, tval: rsp_time, due: cyc + CYC_W'(rsp_lat)};

    logic retire;

    lmr_fifo #(.WIDTH($bits(rsp_t)), .DEPTH(QDEPTH)) u_return_q (
        .clk(clk), .rst_n(rst_n), .push(rsp_push), .din(rq_in), .pop(retire),
        .dout(rq_head), .empty(rq_empty), .full(rsp_full), .count(rq_count));

    // ---------------- timers ----------------
    logic             bus_idle;
    logic [PIPES-1:0] pipe_idle;
    logic             pipe_ok, vrf_ok, due_ok;

    lmr_timer #(.W(TIME_W)) u_bus_tmr (
        .clk(clk), .rst_n(rst_n), .load(retire), .val(rq_head.tval), .idle(bus_idle));

    for (genvar p = 0; p < PIPES; p++) begin : g_pipe_tmr
        lmr_timer #(.W(TIME_W)) u_wait_tmr (
            .clk(clk), .rst_n(rst_n),
            .load(retire && !coissue_en && (rq_head.pipe == PIPE_W'(p))),
            .val(rq_head.tval), .idle(pipe_idle[p]));
    end

    // ---------------- write stage FSM ----------------
    wb_state_e         state;
    logic [NREG_W-1:0] wr_k, cap_n;
    logic [1:0]        cap_esz;
    logic              cap_sgn, cap_wide;
    logic [REG_W-1:0]  cap_dst;
    logic [LANES-1:0]  cap_mask;
    logic [DATA_W-1:0] cap_data;

    assign due_ok  = $signed(cyc - rq_head.due) >= 0;
    assign vrf_ok  = !writes_back(rq_head.op) || vrf_ready;
    assign pipe_ok = coissue_en || (int'(rq_head.pipe) >= PIPES) || pipe_idle[rq_head.pipe];
    assign retire  = !rq_empty && (state == WB_IDLE) && due_ok && vrf_ok && bus_idle && pipe_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= WB_IDLE;
            wr_k     <= '0;
            cap_n    <= '0;
            cap_esz  <= '0;
            cap_sgn  <= 1'b0;
            cap_wide <= 1'b0;
            cap_dst  <= '0;
            cap_mask <= '0;
            cap_data <= '0;
        end else begin
            unique case (state)
                WB_IDLE: begin
                    if (retire && writes_back(rq_head.op) && (rq_head.nreg != '0)) begin
                        state    <= WB_WRITE;
                        wr_k     <= '0;
                        cap_n    <= (rq_head.nreg > NREG_W'(NREG_MAX)) ? NREG_W'(NREG_MAX)
                                                                       : rq_head.nreg;
                        cap_esz  <= rq_head.esz;
                        cap_sgn  <= rq_head.sgn;
                        cap_wide <= rq_head.wide;
                        cap_dst  <= rq_head.dst;
                        cap_mask <= rq_head.mask;
                        cap_data <= rq_head.data;
                    end
                end
                WB_WRITE: begin
                    if (wr_k + 1'b1 >= cap_n) state <= WB_IDLE;
                    else                      wr_k  <= wr_k + 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        rf_we    = '0;
        rf_addr  = '0;
        rf_wide  = 1'b0;
        rf_wdata = '0;
        unique case (state)
            WB_IDLE: ;
            WB_WRITE: begin
                rf_we   = cap_mask;
                rf_addr = cap_dst + REG_W'(wr_k);
                rf_wide = cap_wide;
                for (int i = 0; i < LANES; i++) begin
                    rf_wdata[i*64 +: 64] =
                        widen(cap_data[(int'(wr_k) * LANES + i) * 64 +: 64], cap_esz, cap_sgn, cap_wide);
                end
            end
        endcase
    end

    // ---------------- outstanding counters ----------------
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic hit_in, hit_out;
        assign hit_in  = iss_take && (iss_slot == SLOT_W'(s));
        assign hit_out = retire && (rq_head.slot == SLOT_W'(s));

        lmr_ctr #(.W(CNT_W)) u_total (.clk(clk), .rst_n(rst_n),
            .inc(hit_in), .dec(hit_out), .val(cnt_total[s*CNT_W +: CNT_W]));
        lmr_ctr #(.W(CNT_W)) u_rd (.clk(clk), .rst_n(rst_n),
            .inc(hit_in && counts_read(iss_op)), .dec(hit_out && counts_read(rq_head.op)),
            .val(cnt_rd[s*CNT_W +: CNT_W]));
        lmr_ctr #(.W(CNT_W)) u_wr (.clk(clk), .rst_n(rst_n),
            .inc(hit_in && counts_write(iss_op)), .dec(hit_out && counts_write(rq_head.op)),
            .val(cnt_wr[s*CNT_W +: CNT_W]));
    end

    // ---------------- observation points for the checker ----------------
    logic head_wb, head_tval_nz, wb_active;
    assign head_wb      = writes_back(rq_head.op);
    assign head_tval_nz = (rq_head.tval != '0);
    assign wb_active    = (state == WB_WRITE);

endmodule

// File: rtl/lmr_checker.sv
module lmr_checker #(
    parameter int LANES  = 4,
    parameter int QDEPTH = 4,
    localparam int QC_W  = $clog2(QDEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lds_req_valid,
    input logic             iss_push,
    input logic [QC_W-1:0]  iq_count,
    input logic [QC_W-1:0]  rq_count,
    input logic             retire,
    input logic             head_wb,
    input logic             head_tval_nz,
    input logic             vrf_ready,
    input logic             wb_active,
    input logic [LANES-1:0] rf_we
);
    assert_issue_throttle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lds_req_valid |-> (rq_count < QC_W'(QDEPTH)));

    assert_pop_on_offer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lds_req_valid && !iss_push) |=> (iq_count == $past(iq_count) - 1'b1));

    assert_vrf_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && head_wb) |-> vrf_ready);

    assert_bus_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && head_tval_nz) |=> !retire);

    assert_write_only_in_stage_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_active |-> (rf_we == '0));

    assert_stage_busy_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wb_active |-> !retire);

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rq_count <= QC_W'(QDEPTH));
endmodule

bind lmem_return_pipe lmr_checker #(.LANES(LANES), .QDEPTH(QDEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .lds_req_valid(lds_req_valid), .iss_push(iss_push),
    .iq_count(iq_count), .rq_count(rq_count), .retire(retire), .head_wb(head_wb),
    .head_tval_nz(head_tval_nz), .vrf_ready(vrf_ready), .wb_active(wb_active), .rf_we(rf_we));

// File: tb/tb_lmem_return_pipe.sv
module tb_lmem_return_pipe;
    localparam int LANES = 4, QDEPTH = 4, SLOTS = 4, PIPES = 2, REGS = 16, NREG_MAX = 2;
    localparam int TIME_W = 4, LAT_W = 6, CNT_W = 4, TAG_W = 4;
    localparam int SLOT_W = 2, PIPE_W = 1, REG_W = 4, NREG_W = 2;
    localparam int DATA_W = NREG_MAX * LANES * 64;

    logic clk = 1'b0, rst_n = 1'b0, coissue_en = 1'b0;
    logic iss_push = 1'b0; logic [2:0] iss_op = '0; logic [SLOT_W-1:0] iss_slot = '0;
    logic [TAG_W-1:0] iss_tag = '0; logic iss_full;
    logic lds_req_valid, lds_refused, lds_accept = 1'b1;
    logic [2:0] lds_req_op; logic [SLOT_W-1:0] lds_req_slot; logic [TAG_W-1:0] lds_req_tag;
    logic rsp_push = 1'b0; logic [2:0] rsp_op = '0; logic [1:0] rsp_esz = '0;
    logic rsp_sgn = 1'b0, rsp_wide = 1'b0; logic [REG_W-1:0] rsp_dst = '0;
    logic [NREG_W-1:0] rsp_nreg = '0; logic [LANES-1:0] rsp_mask = '0;
    logic [DATA_W-1:0] rsp_data = '0; logic [SLOT_W-1:0] rsp_slot = '0;
    logic [PIPE_W-1:0] rsp_pipe = '0; logic [TIME_W-1:0] rsp_time = '0;
    logic [LAT_W-1:0] rsp_lat = '0; logic rsp_full; logic vrf_ready = 1'b1;
    logic [LANES-1:0] rf_we; logic [REG_W-1:0] rf_addr; logic rf_wide;
    logic [LANES*64-1:0] rf_wdata;
    logic [SLOTS*CNT_W-1:0] cnt_total, cnt_rd, cnt_wr;

    lmem_return_pipe dut (.*);

    always #10 clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic eq(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        chk(act === exp, req, what, act, exp);
    endtask

    function automatic logic [CNT_W-1:0] cnt(input logic [SLOTS*CNT_W-1:0] v, input int s);
        return v[s*CNT_W +: CNT_W];
    endfunction

    function automatic logic [63:0] elem(input int seed, input int j);
        return 64'hF0E1_D2C3_B4A5_9687 ^ (64'(seed) * 64'h1357_9BDF_2468_ACE1)
               ^ (64'(j) * 64'h0909_8181_7373_8585);
    endfunction

    // independent model of the widening rule
    function automatic logic [63:0] expect_ext(input logic [63:0] raw, input int esz,
                                               input bit sgn, input bit wide);
        int w = 8 << esz;
        logic [63:0] m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        logic [63:0] v = raw & m;
        if (sgn && w < 64 && raw[w-1]) v = v | ~m;
        if (!wide) v = v & 64'h0000_0000_FFFF_FFFF;
        return v;
    endfunction

    task automatic tick(); @(negedge clk); endtask

    task automatic push_iss(input int op, input int slot, input int tag);
        iss_push = 1'b1; iss_op = 3'(op); iss_slot = SLOT_W'(slot); iss_tag = TAG_W'(tag);
        tick();
        iss_push = 1'b0;
    endtask

    task automatic push_rsp(input int op, input int esz, input bit sgn, input bit wide,
                            input int dst, input int nreg, input logic [LANES-1:0] mask,
                            input int slot, input int pipe, input int tv, input int lat, input int seed);
        rsp_push = 1'b1; rsp_op = 3'(op); rsp_esz = 2'(esz); rsp_sgn = sgn; rsp_wide = wide;
        rsp_dst = REG_W'(dst); rsp_nreg = NREG_W'(nreg); rsp_mask = mask;
        rsp_slot = SLOT_W'(slot); rsp_pipe = PIPE_W'(pipe); rsp_time = TIME_W'(tv);
        rsp_lat = LAT_W'(lat);
        for (int j = 0; j < NREG_MAX * LANES; j++) rsp_data[j*64 +: 64] = elem(seed, j);
        tick();
        rsp_push = 1'b0;
    endtask

    task automatic t_reset();
        eq("R10", "req_valid", 64'(lds_req_valid), 0);
        eq("R10", "refused", 64'(lds_refused), 0);
        eq("R10", "rf_we", 64'(rf_we), 0);
        eq("R10", "cnt_total", 64'(cnt_total), 0);
        eq("R10", "cnt_rd", 64'(cnt_rd), 0);
        eq("R10", "cnt_wr", 64'(cnt_wr), 0);
    endtask

    task automatic t_issue();
        push_iss(0, 0, 1);
        eq("R1", "offer valid", 64'(lds_req_valid), 1);
        eq("R1", "offer tag", 64'(lds_req_tag), 1);
        eq("R9", "load rd inc", 64'(cnt(cnt_rd, 0)), 1);
        eq("R9", "load wr none", 64'(cnt(cnt_wr, 0)), 0);
        lds_accept = 1'b0;
        push_iss(1, 1, 2);
        eq("R2", "refused flag", 64'(lds_refused), 1);
        eq("R2", "refused tag", 64'(lds_req_tag), 2);
        lds_accept = 1'b1;
        push_iss(2, 2, 3);
        eq("R2", "popped after refusal", 64'(lds_req_tag), 3);
        push_iss(3, 2, 4);
        push_iss(4, 3, 5);
        tick();
        eq("R2", "queue drained", 64'(lds_req_valid), 0);
        eq("R9", "store wr", 64'(cnt(cnt_wr, 1)), 1);
        eq("R9", "store rd", 64'(cnt(cnt_rd, 1)), 0);
        eq("R9", "atomics rd", 64'(cnt(cnt_rd, 2)), 2);
        eq("R9", "atomics wr", 64'(cnt(cnt_wr, 2)), 2);
        eq("R9", "other wr", 64'(cnt(cnt_wr, 3)), 1);
        eq("R8", "other total", 64'(cnt(cnt_total, 3)), 1);
    endtask

    task automatic t_throttle();
        for (int r = 0; r < QDEPTH; r++) push_rsp(1, 2, 0, 0, 0, 0, '0, 3, 0, 0, 40, r);
        push_iss(0, 0, 6);
        eq("R1", "held while full", 64'(lds_req_valid), 0);
        repeat (35) tick();
        eq("R3", "no retire before latency", 64'(cnt(cnt_total, 3)), 1);
        eq("R1", "still held", 64'(lds_req_valid), 0);
        tick();
        eq("R1", "released after retire", 64'(lds_req_valid), 1);
        eq("R3", "retired at latency", 64'(cnt(cnt_total, 3)), 0);
        repeat (4) tick();
        eq("R8", "total saturates", 64'(cnt(cnt_total, 3)), 0);
        eq("R9", "wr saturates", 64'(cnt(cnt_wr, 3)), 0);
    endtask

    task automatic t_wb(input int op, input int esz, input bit sgn, input bit wide, input int dst,
                        input int nreg, input logic [LANES-1:0] mask, input int slot, input int pipe,
                        input int tv, input int seed);
        push_rsp(op, esz, sgn, wide, dst, nreg, mask, slot, pipe, tv, 1, seed);
        eq("R6", "no write on push edge", 64'(rf_we), 0);
        for (int k = 0; k < nreg; k++) begin
            tick();
            eq("R6", "write mask", 64'(rf_we), 64'(mask));
            eq("R6", "write addr", 64'(rf_addr), 64'((dst + k) % REGS));
            eq("R7", "wide flag", 64'(rf_wide), 64'(wide));
            for (int i = 0; i < LANES; i++)
                if (mask[i])
                    eq("R7", "lane data", rf_wdata[i*64 +: 64],
                       expect_ext(elem(seed, k * LANES + i), esz, sgn, wide));
        end
        tick();
        eq("R6", "write ends", 64'(rf_we), 0);
        repeat (tv) tick();
    endtask

    task automatic t_writeback();
        t_wb(0, 0, 1, 0, 4, 2, 4'b1011, 0, 0, 2, 11);
        eq("R8", "slot0 total", 64'(cnt(cnt_total, 0)), 1);
        eq("R9", "slot0 rd", 64'(cnt(cnt_rd, 0)), 1);
        t_wb(0, 1, 0, 1, 8, 1, 4'b1111, 0, 1, 0, 12);
        eq("R8", "slot0 total zero", 64'(cnt(cnt_total, 0)), 0);
        t_wb(2, 2, 1, 1, 12, 2, 4'b0110, 1, 0, 1, 13);
        eq("R9", "atomic wr dec", 64'(cnt(cnt_wr, 1)), 0);
        eq("R9", "atomic rd saturates", 64'(cnt(cnt_rd, 1)), 0);
        t_wb(0, 3, 0, 1, 14, 2, 4'b1001, 1, 1, 0, 14);
        t_wb(0, 0, 0, 0, 0, 1, 4'b0100, 1, 0, 0, 15);
        t_wb(2, 2, 1, 0, 5, 1, 4'b1111, 1, 0, 0, 16);
    endtask

    task automatic t_store();
        vrf_ready = 1'b0;
        push_rsp(1, 2, 0, 0, 3, 1, 4'b1111, 2, 0, 0, 1, 20);
        eq("R6", "store no write", 64'(rf_we), 0);
        tick();
        eq("R6", "store no write after retire", 64'(rf_we), 0);
        eq("R4", "store ignores vrf_ready", 64'(cnt(cnt_total, 2)), 1);
        eq("R9", "store wr dec", 64'(cnt(cnt_wr, 2)), 1);
        eq("R9", "store rd kept", 64'(cnt(cnt_rd, 2)), 2);
        push_rsp(3, 2, 0, 0, 3, 1, 4'b1111, 2, 0, 0, 1, 21);
        tick();
        eq("R6", "noret atomic no write", 64'(rf_we), 0);
        eq("R9", "noret rd dec", 64'(cnt(cnt_rd, 2)), 1);
        eq("R9", "noret wr dec", 64'(cnt(cnt_wr, 2)), 0);
        vrf_ready = 1'b1;
    endtask

    task automatic t_vrf_gate();
        push_iss(0, 0, 7);
        vrf_ready = 1'b0;
        push_rsp(0, 2, 0, 0, 3, 1, 4'b1111, 0, 0, 0, 1, 30);
        for (int c = 0; c < 5; c++) begin
            tick();
            eq("R4", "load held", 64'(cnt(cnt_total, 0)), 1);
        end
        eq("R4", "no write while held", 64'(rf_we), 0);
        vrf_ready = 1'b1;
        tick();
        eq("R4", "load retires", 64'(cnt(cnt_total, 0)), 0);
        eq("R6", "load writes", 64'(rf_addr), 3);
        tick();
    endtask

    task automatic t_bus_hold();
        push_iss(1, 3, 8);
        push_iss(1, 3, 9);
        push_rsp(1, 2, 0, 0, 0, 0, '0, 3, 0, 3, 1, 40);
        push_rsp(1, 2, 0, 0, 0, 0, '0, 3, 1, 3, 1, 41);
        eq("R5", "first retired", 64'(cnt(cnt_total, 3)), 1);
        repeat (3) tick();
        eq("R5", "second held by bus", 64'(cnt(cnt_total, 3)), 1);
        tick();
        eq("R5", "second retires after hold", 64'(cnt(cnt_total, 3)), 0);
    endtask

    task automatic t_order();
        push_iss(0, 0, 10);
        push_iss(0, 0, 11);
        push_rsp(0, 2, 0, 0, 2, 1, 4'b1111, 0, 0, 0, 6, 50);
        push_rsp(0, 2, 0, 0, 10, 1, 4'b1111, 0, 0, 0, 1, 51);
        for (int c = 0; c < 4; c++) begin
            tick();
            eq("R11", "ready second waits", 64'(rf_we), 0);
        end
        tick();
        eq("R11", "first in order", 64'(rf_addr), 2);
        tick();
        eq("R11", "stage gap", 64'(rf_we), 0);
        tick();
        eq("R11", "second after first", 64'(rf_addr), 10);
        eq("R8", "both retired", 64'(cnt(cnt_total, 0)), 0);
        tick();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_issue();
        t_throttle();
        t_writeback();
        t_store();
        t_vrf_gate();
        t_bus_hold();
        t_order();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule